// File: doc/BRIEF.md
# Register-Driven Load-Linked / Store-Conditional Unit

This block lets software carry out an atomic read-modify-write using ordinary register accesses instead of dedicated instructions. Software writes a word address to the link register, and the unit fetches that word over its memory master port. Software then reads the fetched value from the data register and writes a modified value back to it. That write is stored to the linked address only if nothing has disturbed the sequence since the link was made.

Four kinds of disturbance are watched for while a link is open: a read of the same word by another master, a bus-lock request, a pending interrupt, and an error response from memory. Each one sets its own flag in the status register. Any flag that is set cancels the store. Software reads the status register after the data write to learn whether the update took effect. Every store attempt, whether it succeeds or is cancelled, closes the link.

Top module: `llsc_unit`

## Requirements
- R1: Writing an address with its two low bits zero to offset 0x0 starts a single memory read of that address. Once the read completes, offset 0x4 returns the word that memory supplied.
- R2: A write to offset 0x0 clears every abort flag. After a clean fetch, the status register at offset 0x8 reads 0.
- R3: A write to offset 0x4 while the link is valid and no flag is set issues exactly one memory write of that value to the linked address. Status then reads 0.
- R4: A read by another master (snoop_rd_i) whose address falls in the same word as the link, seen while the link is open, sets status bit 0 and suppresses the store. A snoop read of a different word leaves bit 0 clear and the store goes ahead.
- R5: bus_lock_i seen while the link is open sets status bit 1 and suppresses the store.
- R6: irq_pend_i seen while the link is open sets status bit 2 and suppresses the store.
- R7: An error response from memory sets status bit 3. An error on the fetch also closes the link, so a following data write stores nothing.
- R8: Status bit 4 is 1 while a fetch or store is in progress. During that time, accesses to offsets 0x0 and 0x4 are held off with reg_ready_o low. Status reads never wait. The reset state is all registers 0 and the port idle.
- R9: A data write with no open link, either because no address was written or because a store was already attempted, issues no memory write and sets status bit 0.
- R10: An address with a nonzero value in its two low bits sets status bit 3 and starts no memory access.
- R11: Events that occur outside the open link, whether before the address write or after the data write, set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register offset (0x0 link, 0x4 data, 0x8 status) |
| reg_wdata_i | input | W | Register write data |
| reg_rdata_o | output | W | Register read data, valid while request and ready are both high |
| reg_ready_o | output | 1 | Access accepted on this clock edge |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write when 1, read when 0 |
| mem_addr_o | output | W | Memory byte address |
| mem_wdata_o | output | W | Memory write data |
| mem_rdata_i | input | W | Memory read data, valid with the acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_err_i | input | 1 | Error response, valid with the acknowledge |
| snoop_rd_i | input | 1 | Another master is reading |
| snoop_addr_i | input | W | Address of that read |
| bus_lock_i | input | 1 | Bus-lock request seen |
| irq_pend_i | input | 1 | Interrupt pending |

## Verification
The bench builds the unit with W = 32, so addresses are byte addresses with two alignment bits. It varies the memory latency from zero to five wait cycles. A long latency keeps the fetch or store in flight across several register accesses, which exposes the wait states on the link and data registers and the busy bit on status reads. The same long latency places interrupt pulses inside a store that has already been committed. The bench also injects one-shot error responses on the fetch and on the store separately, and it aims snoop reads both at another byte of the linked word and at a neighbouring word.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam int unsigned OFFW = 4;
  localparam logic [OFFW-1:0] OFF_ADDR = 4'h0;
  localparam logic [OFFW-1:0] OFF_DATA = 4'h4;
  localparam logic [OFFW-1:0] OFF_STAT = 4'h8;
  localparam int unsigned NFLAG   = 4;
  localparam int unsigned FL_RD   = 0;
  localparam int unsigned FL_LOCK = 1;
  localparam int unsigned FL_IRQ  = 2;
  localparam int unsigned FL_BERR = 3;
  localparam int unsigned ST_BUSY = 4;
  typedef enum logic [1:0] {PH_IDLE, PH_FETCH, PH_STORE} phase_e;
endpackage

// File: rtl/llsc_mem_port.sv
module llsc_mem_port import llsc_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fetch_i,
  input  logic         store_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         mem_ack_i,
  input  logic         mem_err_i,
  output logic         busy_o,
  output logic         fetch_done_o,
  output logic         err_done_o
);
  phase_e phase_q;
  logic   done;

  assign mem_req_o    = (phase_q != PH_IDLE);
  assign mem_we_o     = (phase_q == PH_STORE);
  assign mem_addr_o   = addr_i;
  assign mem_wdata_o  = wdata_i;
  assign busy_o       = mem_req_o;
  assign done         = mem_req_o && mem_ack_i;
  assign fetch_done_o = done && (phase_q == PH_FETCH);
  assign err_done_o   = done && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (fetch_i)      phase_q <= PH_FETCH;
          else if (store_i) phase_q <= PH_STORE;
        end
        default: if (mem_ack_i) phase_q <= PH_IDLE;
      endcase
    end
  end

  // R1
  handshake_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
endmodule

// File: rtl/llsc_watch.sv
module llsc_watch import llsc_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             misalign_i,
  input  logic             window_i,
  input  logic             snoop_rd_i,
  input  logic [W-1:0]     snoop_addr_i,
  input  logic [W-1:0]     link_addr_i,
  input  logic             bus_lock_i,
  input  logic             irq_pend_i,
  input  logic             berr_i,
  input  logic             nolink_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             abort_o
);
  localparam int unsigned AB = $clog2(W/8);

  logic [NFLAG-1:0] flags_q, set, nxt;
  logic             hit;

  // word compare: byte lanes inside the word do not matter
  assign hit = snoop_rd_i && (((snoop_addr_i ^ link_addr_i) >> AB) == '0);

  always_comb begin
    set          = '0;
    set[FL_RD]   = (window_i && hit) || nolink_i;
    set[FL_LOCK] = window_i && bus_lock_i;
    set[FL_IRQ]  = window_i && irq_pend_i;
    set[FL_BERR] = berr_i;
    if (clr_i) begin
      nxt          = '0;
      nxt[FL_BERR] = misalign_i;
    end else begin
      nxt = flags_q | set;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= nxt;
  end

  assign flags_o = flags_q;
  assign abort_o = |nxt;
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit import llsc_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [OFFW-1:0] reg_addr_i,
  input  logic [W-1:0]    reg_wdata_i,
  output logic [W-1:0]    reg_rdata_o,
  output logic            reg_ready_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [W-1:0]    mem_addr_o,
  output logic [W-1:0]    mem_wdata_o,
  input  logic [W-1:0]    mem_rdata_i,
  input  logic            mem_ack_i,
  input  logic            mem_err_i,
  input  logic            snoop_rd_i,
  input  logic [W-1:0]    snoop_addr_i,
  input  logic            bus_lock_i,
  input  logic            irq_pend_i
);
  localparam int unsigned AB = $clog2(W/8);

  logic             busy, acc, aw_acc, dw_acc, misalign, go_store, abort;
  logic             linked_q, fetch_done, berr;
  logic [W-1:0]     link_addr_q, data_q;
  logic [NFLAG-1:0] flags;

  // only the status register stays reachable during a memory cycle
  assign reg_ready_o = !busy || (reg_addr_i == OFF_STAT);
  assign acc      = reg_req_i && reg_ready_o;
  assign aw_acc   = acc && reg_we_i && (reg_addr_i == OFF_ADDR);
  assign dw_acc   = acc && reg_we_i && (reg_addr_i == OFF_DATA);
  assign misalign = |reg_wdata_i[AB-1:0];
  assign go_store = dw_acc && linked_q && !abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_addr_q <= '0;
      linked_q    <= 1'b0;
      data_q      <= '0;
    end else begin
      if (aw_acc) link_addr_q <= reg_wdata_i;
      if (aw_acc)                           linked_q <= !misalign;
      else if (dw_acc || (fetch_done && berr)) linked_q <= 1'b0;
      if (fetch_done)  data_q <= mem_rdata_i;
      else if (dw_acc) data_q <= reg_wdata_i;
    end
  end

  llsc_mem_port #(.W(W)) i_port (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_i      (aw_acc && !misalign),
    .store_i      (go_store),
    .addr_i       (link_addr_q),
    .wdata_i      (data_q),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_err_i    (mem_err_i),
    .busy_o       (busy),
    .fetch_done_o (fetch_done),
    .err_done_o   (berr)
  );

  llsc_watch #(.W(W)) i_watch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (aw_acc),
    .misalign_i   (misalign),
    .window_i     (linked_q),
    .snoop_rd_i   (snoop_rd_i),
    .snoop_addr_i (snoop_addr_i),
    .link_addr_i  (link_addr_q),
    .bus_lock_i   (bus_lock_i),
    .irq_pend_i   (irq_pend_i),
    .berr_i       (berr),
    .nolink_i     (dw_acc && !linked_q),
    .flags_o      (flags),
    .abort_o      (abort)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_ADDR: reg_rdata_o = link_addr_q;
      OFF_DATA: reg_rdata_o = data_q;
      OFF_STAT: reg_rdata_o = {{(W-NFLAG-1){1'b0}}, busy, flags};
      default:  reg_rdata_o = '0;
    endcase
  end

  // R2
  clear_on_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_acc && !misalign) |=> (flags == '0));
  // R3
  clean_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (!flags[FL_RD] && !flags[FL_LOCK] && !flags[FL_IRQ]));
  // R10
  misalign_nofetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_acc && misalign) |=> (!mem_req_o && flags[FL_BERR]));
  // R1
  fetch_linked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> linked_q);
endmodule

// File: tb/test_llsc_unit.sv
module test_llsc_unit;
  localparam int unsigned W = 32;
  localparam int P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata_o;
  logic reg_ready_o, mem_req_o, mem_we_o;
  logic [W-1:0] mem_addr_o, mem_wdata_o;
  logic [W-1:0] mem_rdata = 32'hdead0000;
  logic mem_ack = 0, mem_err = 0;
  logic snoop_rd = 0, bus_lock = 0, irq_pend = 0;
  logic [W-1:0] snoop_addr = 0;

  int n_chk = 0, n_fail = 0, cyc = 0, lat = 0, wcnt = 0, req_cycles = 0;
  bit err_arm = 0, done = 0;
  logic [W-1:0] mem [16];

  // reference model state
  int m_state = 0;
  bit m_linked = 0;
  logic [3:0] m_flags = 0;
  logic [W-1:0] m_laddr = 0, m_data = 0;

  always #(P/2) clk = ~clk;

  llsc_unit #(.W(W)) i_llsc_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata_o), .reg_ready_o(reg_ready_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .snoop_rd_i(snoop_rd), .snoop_addr_i(snoop_addr),
    .bus_lock_i(bus_lock), .irq_pend_i(irq_pend)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] m_read(input logic [3:0] off);
    case (off)
      4'h0: return m_laddr;
      4'h4: return m_data;
      4'h8: return {27'd0, (m_state != 0), m_flags};
      default: return '0;
    endcase
  endfunction

  function automatic bit m_ready();
    return (m_state == 0) || (reg_addr == 4'h8);
  endfunction

  // memory responder: decides at negedge what the next edge sees
  always @(negedge clk) begin
    if (mem_req_o) begin
      req_cycles++;
      if (wcnt == lat) begin
        mem_ack = 1; mem_err = err_arm;
        mem_rdata = mem[mem_addr_o[5:2]];
        if (mem_we_o && !err_arm) mem[mem_addr_o[5:2]] = mem_wdata_o;
        err_arm = 0; wcnt = 0;
      end else begin
        mem_ack = 0; mem_err = 0; wcnt++;
      end
    end else begin
      mem_ack = 0; mem_err = 0; wcnt = 0;
    end
  end

  // behavioural model, advanced on each edge from the bench-driven inputs
  always @(posedge clk) begin
    bit acc, aw, dw, hit;
    if (rst_n) begin
      acc = reg_req && ((reg_addr == 4'h8) || (m_state == 0));
      aw  = acc && reg_we && (reg_addr == 4'h0);
      dw  = acc && reg_we && (reg_addr == 4'h4);
      hit = snoop_rd && ((snoop_addr >> 2) == (m_laddr >> 2));
      if (aw) begin
        m_laddr = reg_wdata;
        if (reg_wdata[1:0] != 0) begin m_flags = 4'h8; m_linked = 0; end
        else begin m_flags = 0; m_linked = 1; m_state = 1; end
      end else begin
        if (m_linked) begin
          if (hit) m_flags[0] = 1;
          if (bus_lock) m_flags[1] = 1;
          if (irq_pend) m_flags[2] = 1;
        end
        if (m_state == 1 && mem_ack) begin
          m_data = mem_rdata;
          if (mem_err) begin m_flags[3] = 1; m_linked = 0; end
          m_state = 0;
        end else if (m_state == 2 && mem_ack) begin
          if (mem_err) m_flags[3] = 1;
          m_state = 0;
        end
        if (dw) begin
          m_data = reg_wdata;
          if (!m_linked) m_flags[0] = 1;
          else if (m_flags == 0) m_state = 2;
          m_linked = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #(P/4);
    if (rst_n && !done) begin
      check(mem_req_o == (m_state != 0), "R1 mem_req", mem_req_o, (m_state != 0));
      check(mem_we_o == (m_state == 2), "R3 mem_we", mem_we_o, (m_state == 2));
      check(reg_ready_o == m_ready(), "R8 ready", reg_ready_o, m_ready());
      if (m_state != 0)
        check(mem_addr_o == m_laddr, "R1 mem_addr", mem_addr_o, m_laddr);
    end
  end

  task automatic acc(input bit we, input logic [3:0] off, input logic [W-1:0] wd,
                     output logic [W-1:0] rd, output int stalls);
    stalls = 0;
    @(negedge clk);
    reg_req = 1; reg_we = we; reg_addr = off; reg_wdata = wd;
    #(P/4);
    while (!reg_ready_o && stalls < 1000) begin
      stalls++; @(negedge clk); #(P/4);
    end
    rd = reg_rdata_o;
    if (!we) check(rd == m_read(off), "R2 model readback", rd, m_read(off));
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [W-1:0] wd);
    logic [W-1:0] rd; int s;
    acc(1, off, wd, rd, s);
  endtask

  task automatic rdv(input logic [3:0] off, output logic [W-1:0] rd);
    int s;
    acc(0, off, '0, rd, s);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && mem_req_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int kind, input logic [W-1:0] a);
    @(negedge clk);
    case (kind)
      0: begin snoop_rd = 1; snoop_addr = a; end
      1: bus_lock = 1;
      default: irq_pend = 1;
    endcase
    @(negedge clk);
    snoop_rd = 0; bus_lock = 0; irq_pend = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] rd;
    int s, rc;
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rdv(4'h8, rd); check(rd == 0, "R8 reset status", rd, 0);
    rdv(4'h4, rd); check(rd == 0, "R8 reset data", rd, 0);
    check(mem_req_o == 0, "R8 reset port idle", mem_req_o, 0);

    // data write with no link
    wr(4'h4, 32'h1234);
    rdv(4'h8, rd); check(rd == 1, "R9 no link", rd, 1);
    check(mem[0] == 32'h1000, "R9 no store", mem[0], 32'h1000);

    // full sequence, slow memory
    lat = 3;
    wr(4'h0, 32'h8);
    acc(0, 4'h4, '0, rd, s);
    check(s > 0, "R8 data read stalls", s, 1);
    check(rd == 32'h1002, "R1 fetched word", rd, 32'h1002);
    rdv(4'h8, rd); check(rd == 0, "R2 flags cleared", rd, 0);
    wr(4'h4, 32'h1007); wait_idle();
    rdv(4'h8, rd); check(rd == 0, "R3 status ok", rd, 0);
    check(mem[2] == 32'h1007, "R3 stored", mem[2], 32'h1007);
    wr(4'h4, 32'h2222); wait_idle();
    rdv(4'h8, rd); check(rd == 1, "R9 link spent", rd, 1);
    check(mem[2] == 32'h1007, "R9 no second store", mem[2], 32'h1007);

    // snoop hit on another byte of the word, then miss
    lat = 0;
    wr(4'h0, 32'hC); pulse(0, 32'hE);
    wr(4'h4, 32'hAAAA); wait_idle();
    rdv(4'h8, rd); check(rd == 1, "R4 snoop hit", rd, 1);
    check(mem[3] == 32'h1003, "R4 store blocked", mem[3], 32'h1003);
    wr(4'h0, 32'hC); pulse(0, 32'h10);
    wr(4'h4, 32'hBBBB); wait_idle();
    rdv(4'h8, rd); check(rd == 0, "R4 snoop miss", rd, 0);
    check(mem[3] == 32'hBBBB, "R4 store done", mem[3], 32'hBBBB);

    // bus lock and interrupt
    wr(4'h0, 32'h10); pulse(1, 0);
    wr(4'h4, 32'h4444); wait_idle();
    rdv(4'h8, rd); check(rd == 2, "R5 lock", rd, 2);
    check(mem[4] == 32'h1004, "R5 store blocked", mem[4], 32'h1004);
    wr(4'h0, 32'h14); pulse(2, 0);
    wr(4'h4, 32'h5555); wait_idle();
    rdv(4'h8, rd); check(rd == 4, "R6 irq", rd, 4);
    check(mem[5] == 32'h1005, "R6 store blocked", mem[5], 32'h1005);

    // errors on fetch and on store
    lat = 2;
    err_arm = 1; wr(4'h0, 32'h18); wait_idle();
    rdv(4'h8, rd); check(rd == 8, "R7 fetch error", rd, 8);
    wr(4'h4, 32'h7777); wait_idle();
    rdv(4'h8, rd); check(rd == 9, "R7 link closed", rd, 9);
    check(mem[6] == 32'h1006, "R7 no store", mem[6], 32'h1006);
    wr(4'h0, 32'h1C); wait_idle();
    err_arm = 1; wr(4'h4, 32'h8888); wait_idle();
    rdv(4'h8, rd); check(rd == 8, "R7 store error", rd, 8);

    // misaligned link address
    rc = req_cycles;
    wr(4'h0, 32'h22); repeat (5) @(negedge clk);
    check(req_cycles == rc, "R10 no fetch", req_cycles, rc);
    rdv(4'h8, rd); check(rd == 8, "R10 status", rd, 8);

    // events outside the open link
    lat = 3;
    pulse(2, 0); pulse(1, 0);
    wr(4'h0, 32'h24);
    wr(4'h4, 32'h9999); pulse(2, 0); pulse(0, 32'h24);
    wait_idle();
    rdv(4'h8, rd); check(rd == 0, "R11 outside window", rd, 0);
    check(mem[9] == 32'h9999, "R11 store done", mem[9], 32'h9999);

    // status read during a fetch
    lat = 5;
    wr(4'h0, 32'h28);
    acc(0, 4'h8, '0, rd, s);
    check(s == 0, "R8 status no stall", s, 0);
    check(rd == 32'h10, "R8 busy bit", rd, 32'h10);
    wait_idle();
    rdv(4'h4, rd); check(rd == 32'h100A, "R1 slow fetch", rd, 32'h100A);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule